// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the target side of a three-wire serial programming link (serial clock, data in, data out). It is active while the device is held in its programming hold state. Serial traffic arrives asynchronously to the system clock. The block synchronizes it and groups it into four-byte instructions. It decodes an enable instruction, page-buffer loads, a page write, word reads and a busy poll.

Word writes are staged in a page buffer of `2**WORD_BITS` 16-bit words. For each word, the low byte must be loaded before the high byte. A page-write instruction names the destination page. It raises a one-cycle commit request and starts a fixed busy window of `BUSY_CYCLES` clocks. At the end of that window, the complete words are copied into a register-array model of the non-volatile memory. Until a valid enable sequence has been seen, the block acts on nothing but that sequence. Releasing the hold input resets the framing, so the programmer can resynchronize with a new enable.

Top module: `sprog_target`

## Requirements
- R1: Data in is sampled on rising serial clock edges, most significant bit first. Data out changes only in response to falling serial clock edges and stays stable while the serial clock is high.
- R2: Traffic is framed in four-byte instructions. All four bytes are counted whether or not the enable pattern matched, and only the fourth byte completes an instruction.
- R3: During the second, third and fourth byte of an instruction, data out returns the previous byte of the same instruction. An enable 0xAC 0x53 therefore echoes 0x53 during its third byte. The exception is the response slot of R9 and R12.
- R4: Until an instruction with first byte 0xAC and second byte 0x53 completes, every other instruction has no effect, and the fourth-byte slot echoes byte three.
- R5: Load-low (first byte 0x40) takes its buffer word index from the low `WORD_BITS` bits of byte three. Byte four becomes that word's low byte, and the word is marked as holding a pending low byte.
- R6: Load-high (first byte 0x48) is accepted only if the word holds a pending low byte. When accepted, byte four becomes the high byte, the word becomes complete and the pending mark clears. Otherwise the instruction is ignored.
- R7: Write-page (first byte 0x4C) selects the page from the low `PAGE_SEL_BITS` bits of byte two; the upper bits are ignored. It pulses `commit_o` for one cycle. When the busy window ends, every complete buffer word is written to that page, every other word of the page keeps its value, and all buffer marks clear. The array reads 0xFFFF after reset.
- R8: `busy_o` rises in the same cycle as `commit_o` and stays high for exactly `BUSY_CYCLES` clock cycles.
- R9: Poll (first byte 0xF0) returns the busy flag in bit 0 of the fourth-byte response, with bits 7..1 at zero.
- R10: While busy, load, write-page and read instructions are ignored. A read made while busy echoes byte three in its response slot.
- R11: After reset, or whenever the hold input is low, the framing counters, the data-out shift state and the enable state are cleared. Data out is then low; `commit_o` and `busy_o` are low after reset.
- R12: Read-low (0x20) and read-high (0x28) take the page from byte two and the word from byte three. The fourth-byte response returns the low or high byte of that array word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tgt_hold_i | input | 1 | High while the device is held for programming; low resets the framing |
| sck_i | input | 1 | Serial clock from the programmer (asynchronous) |
| mosi_i | input | 1 | Serial data from the programmer (asynchronous) |
| miso_o | output | 1 | Serial data to the programmer |
| commit_o | output | 1 | One-cycle page-commit request |
| busy_o | output | 1 | High while a page write is in progress |

## Verification
The serial inputs go through a two-flop synchronizer and an edge detector. A serial-clock edge therefore takes effect on the third system clock after it. Data out settles three clocks after a falling edge, and an instruction executes three clocks after its last rising edge. The bench holds each serial clock phase for five system clocks and samples data out at the end of the low phase. It also samples data out again at the end of the high phase to confirm it did not move. After each instruction the bench waits four more clocks. `commit_o` and `busy_o` rise one edge after execution. A monitor on falling system-clock edges counts the busy cycles from the commit pulse, so that count can be compared exactly with `BUSY_CYCLES`.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  localparam logic [7:0] EN_B0      = 8'hAC;
  localparam logic [7:0] EN_B1      = 8'h53;
  localparam logic [7:0] OP_LD_LO   = 8'h40;
  localparam logic [7:0] OP_LD_HI   = 8'h48;
  localparam logic [7:0] OP_WR_PG   = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LD_LO,
    CMD_LD_HI,
    CMD_WR_PG,
    CMD_RD_LO,
    CMD_RD_HI,
    CMD_POLL
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    case (op)
      OP_LD_LO: return CMD_LD_LO;
      OP_LD_HI: return CMD_LD_HI;
      OP_WR_PG: return CMD_WR_PG;
      OP_RD_LO: return CMD_RD_LO;
      OP_RD_HI: return CMD_RD_HI;
      OP_POLL:  return CMD_POLL;
      default:  return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic mosi_o,
  output logic hold_o
);

  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] mosi_q;
  logic [STAGES-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      mosi_q <= '0;
      hold_q <= '0;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      hold_q <= {hold_q[STAGES-2:0], hold_i};
    end
  end

  // extra sck stage only for edge detection
  assign sck_rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign mosi_o     = mosi_q[STAGES-1];
  assign hold_o     = hold_q[STAGES-1];

endmodule

// File: rtl/sprog_frame.sv
module sprog_frame (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_i,
  output logic       byte_done_o,
  output logic [1:0] byte_idx_o,
  output logic [7:0] rx_o,
  output logic [7:0] b0_o,
  output logic [7:0] b1_o,
  output logic [7:0] b2_o,
  output logic       miso_o
);

  logic [2:0] bit_cnt_q;
  logic [1:0] byte_cnt_q;
  logic [7:0] rx_sr_q, tx_nx_q, tx_sr_q;

  assign rx_o        = {rx_sr_q[6:0], mosi_i};
  assign byte_done_o = active_i & rise_i & (bit_cnt_q == 3'd7);
  assign byte_idx_o  = byte_cnt_q;
  assign miso_o      = tx_sr_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_sr_q    <= '0;
      tx_nx_q    <= '0;
      tx_sr_q    <= '0;
      b0_o       <= '0;
      b1_o       <= '0;
      b2_o       <= '0;
    end else if (!active_i) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      tx_nx_q    <= '0;
      tx_sr_q    <= '0;
    end else begin
      if (rise_i) begin
        rx_sr_q   <= rx_o;
        bit_cnt_q <= bit_cnt_q + 3'd1;
      end
      if (byte_done_o) begin
        byte_cnt_q <= byte_cnt_q + 2'd1;
        tx_nx_q    <= tx_i;
        case (byte_cnt_q)
          2'd0:    b0_o <= rx_o;
          2'd1:    b1_o <= rx_o;
          2'd2:    b2_o <= rx_o;
          default: ;
        endcase
      end
      // first falling edge after a byte boundary loads the next byte
      if (fall_i) tx_sr_q <= (bit_cnt_q == 3'd0) ? tx_nx_q : {tx_sr_q[6:0], 1'b0};
    end
  end

  a_r1_miso_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_i) && !$past(fall_i)) |-> $stable(miso_o));

  a_r11_idle_when_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (miso_o == 1'b0 && byte_idx_o == 2'd0));

endmodule

// File: rtl/sprog_pagebuf.sv
module sprog_pagebuf #(
  parameter int WORD_BITS = 6,
  localparam int WORDS = 1 << WORD_BITS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ld_lo_i,
  input  logic                      ld_hi_i,
  input  logic [WORD_BITS-1:0]      waddr_i,
  input  logic [7:0]                data_i,
  input  logic                      clear_i,
  output logic [WORDS-1:0][15:0]    words_o,
  output logic [WORDS-1:0]          full_o
);

  logic [WORDS-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_o <= '0;
      lo_q    <= '0;
      full_o  <= '0;
    end else if (clear_i) begin
      lo_q   <= '0;
      full_o <= '0;
    end else if (ld_lo_i) begin
      words_o[waddr_i][7:0] <= data_i;
      lo_q[waddr_i]         <= 1'b1;
      full_o[waddr_i]       <= 1'b0;
    end else if (ld_hi_i && lo_q[waddr_i]) begin
      words_o[waddr_i][15:8] <= data_i;
      lo_q[waddr_i]          <= 1'b0;
      full_o[waddr_i]        <= 1'b1;
    end
  end

  a_r6_hi_needs_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hi_i && !ld_lo_i && !clear_i && !lo_q[waddr_i]) |=> $stable(full_o));

endmodule

// File: rtl/sprog_nvm.sv
module sprog_nvm #(
  parameter int WORD_BITS     = 6,
  parameter int PAGE_SEL_BITS = 2,
  parameter int BUSY_CYCLES   = 64,
  localparam int WORDS = 1 << WORD_BITS,
  localparam int PAGES = 1 << PAGE_SEL_BITS,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [PAGE_SEL_BITS-1:0]  page_i,
  input  logic [WORDS-1:0][15:0]    words_i,
  input  logic [WORDS-1:0]          full_i,
  input  logic [PAGE_SEL_BITS-1:0]  rd_page_i,
  input  logic [WORD_BITS-1:0]      rd_word_i,
  output logic [15:0]               rd_data_o,
  output logic                      busy_o,
  output logic                      done_o
);

  logic [CNT_W-1:0]               cnt_q;
  logic [PAGE_SEL_BITS-1:0]       pg_q;
  logic [PAGES-1:0][WORDS-1:0][15:0] mem_q;

  assign busy_o    = cnt_q != '0;
  assign done_o    = cnt_q == CNT_W'(1);
  assign rd_data_o = mem_q[rd_page_i][rd_word_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pg_q  <= '0;
    end else if (commit_i && !busy_o) begin
      cnt_q <= CNT_W'(BUSY_CYCLES);
      pg_q  <= page_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // array lands at the end of the write window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '1;
    end else if (done_o) begin
      for (int w = 0; w < WORDS; w++) begin
        if (full_i[w]) mem_q[pg_q][w] <= words_i[w];
      end
    end
  end

  a_r10_no_commit_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_o);

  a_r8_busy_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i));

  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
#(
  parameter int WORD_BITS     = 6,
  parameter int PAGE_SEL_BITS = 2,
  parameter int BUSY_CYCLES   = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgt_hold_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic commit_o,
  output logic busy_o
);

  localparam int WORDS       = 1 << WORD_BITS;
  localparam int SYNC_STAGES = 2;

  logic sck_rise, sck_fall, mosi_s, hold_s;

  sprog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .hold_i     (tgt_hold_i),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .mosi_o     (mosi_s),
    .hold_o     (hold_s)
  );

  logic       byte_done;
  logic [1:0] byte_idx;
  logic [7:0] rx_byte, b0, b1, b2, tx_byte;

  sprog_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (hold_s),
    .rise_i      (sck_rise),
    .fall_i      (sck_fall),
    .mosi_i      (mosi_s),
    .tx_i        (tx_byte),
    .byte_done_o (byte_done),
    .byte_idx_o  (byte_idx),
    .rx_o        (rx_byte),
    .b0_o        (b0),
    .b1_o        (b1),
    .b2_o        (b2),
    .miso_o      (miso_o)
  );

  cmd_e cmd;
  logic enabled_q, exec, act, ld_lo, ld_hi, wr_pg, wr_done;

  assign cmd   = decode_op(b0);
  assign exec  = byte_done && (byte_idx == 2'd3);
  assign act   = exec && enabled_q && !busy_o;
  assign ld_lo = act && (cmd == CMD_LD_LO);
  assign ld_hi = act && (cmd == CMD_LD_HI);
  assign wr_pg = act && (cmd == CMD_WR_PG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enabled_q <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      commit_o <= wr_pg;
      if (!hold_s)                                  enabled_q <= 1'b0;
      else if (exec && b0 == EN_B0 && b1 == EN_B1)  enabled_q <= 1'b1;
    end
  end

  logic [WORDS-1:0][15:0] buf_words;
  logic [WORDS-1:0]       buf_full;
  logic [15:0]            rd_data;

  sprog_pagebuf #(.WORD_BITS(WORD_BITS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_lo_i (ld_lo),
    .ld_hi_i (ld_hi),
    .waddr_i (b2[WORD_BITS-1:0]),
    .data_i  (rx_byte),
    .clear_i (wr_done),
    .words_o (buf_words),
    .full_o  (buf_full)
  );

  sprog_nvm #(
    .WORD_BITS     (WORD_BITS),
    .PAGE_SEL_BITS (PAGE_SEL_BITS),
    .BUSY_CYCLES   (BUSY_CYCLES)
  ) u_nvm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (wr_pg),
    .page_i    (b1[PAGE_SEL_BITS-1:0]),
    .words_i   (buf_words),
    .full_i    (buf_full),
    .rd_page_i (b1[PAGE_SEL_BITS-1:0]),
    .rd_word_i (rx_byte[WORD_BITS-1:0]),
    .rd_data_o (rd_data),
    .busy_o    (busy_o),
    .done_o    (wr_done)
  );

  // response for the fourth byte is chosen when the third completes
  always_comb begin
    tx_byte = rx_byte;
    if (byte_idx == 2'd2 && enabled_q) begin
      case (cmd)
        CMD_RD_LO: if (!busy_o) tx_byte = rd_data[7:0];
        CMD_RD_HI: if (!busy_o) tx_byte = rd_data[15:8];
        CMD_POLL:  tx_byte = {7'b0, busy_o};
        default:   ;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{b1[7:PAGE_SEL_BITS], b2[7:WORD_BITS]};

  a_r4_commit_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(enabled_q));

  a_r8_busy_with_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> busy_o);

endmodule

// File: tb/sim_sprog_target.sv
module sim_sprog_target;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 5;
  localparam int WB         = 4;
  localparam int PS         = 2;
  localparam int BUSY       = 2000;
  localparam int WORDS      = 1 << WB;
  localparam int PAGES      = 1 << PS;
  localparam int WD_CYCLES  = 195000;

  localparam logic [7:0] C_LLO = 8'h40, C_LHI = 8'h48, C_WR = 8'h4C;
  localparam logic [7:0] C_RLO = 8'h20, C_RHI = 8'h28, C_POLL = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, commit, busy;

  sprog_target #(.WORD_BITS(WB), .PAGE_SEL_BITS(PS), .BUSY_CYCLES(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tgt_hold_i(hold), .sck_i(sck),
    .mosi_i(mosi), .miso_o(miso), .commit_o(commit), .busy_o(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, edge_err = 0, ccount = 0, busy_len = 0, c0 = 0;
  bit done = 1'b0;
  logic [31:0] r;
  logic [15:0] d;
  logic [15:0] expm [PAGES][WORDS];

  always @(negedge clk) begin
    if (commit) begin ccount++; busy_len = 1; end
    else if (busy) busy_len++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== rx[i]) edge_err++;
      sck = 1'b0;
    end
  endtask

  task automatic instr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] e, output logic [31:0] res);
    logic [7:0] q0, q1, q2, q3;
    xbyte(a, q0); xbyte(b, q1); xbyte(c, q2); xbyte(e, q3);
    res = {q0, q1, q2, q3};
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int p, input int w);
    return 16'((p * WORDS + w + 1) * 40503) ^ 16'h3C5A;
  endfunction

  initial begin
    repeat (WD_CYCLES) @(negedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < PAGES; p++)
      for (int w = 0; w < WORDS; w++) expm[p][w] = 16'hFFFF;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(miso == 1'b0 && busy == 1'b0 && commit == 1'b0, "R11 reset outputs",
        {miso, busy, commit}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hold = 1'b1;
    repeat (6) @(negedge clk);

    // R4: nothing acts before enable
    instr(C_LLO, 8'h00, 8'h00, 8'h12, r);
    instr(C_WR, 8'h00, 8'h00, 8'h00, r);
    repeat (4) @(negedge clk);
    chk(ccount == 0, "R4 write before enable", ccount, 0);
    instr(C_POLL, 8'h00, 8'h77, 8'h00, r);
    chk(r[7:0] == 8'h77, "R4 poll before enable echoes", r[7:0], 8'h77);
    instr(C_RLO, 8'h00, 8'h00, 8'h00, r);
    chk(r[7:0] == 8'h00, "R4 read before enable echoes", r[7:0], 8'h00);

    // R3/R2: wrong pattern echoes, stays disabled, framing keeps four bytes
    instr(8'hAC, 8'h52, 8'h9A, 8'h00, r);
    chk(r[15:8] == 8'h52, "R3 echo second byte", r[15:8], 8'h52);
    chk(r[7:0] == 8'h9A, "R3 echo third byte", r[7:0], 8'h9A);
    instr(C_WR, 8'h00, 8'h00, 8'h00, r);
    repeat (4) @(negedge clk);
    chk(ccount == 0, "R4 bad enable keeps disabled", ccount, 0);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk(r[23:16] == 8'hAC, "R2 frame aligned after bad enable", r[23:16], 8'hAC);
    chk(r[15:8] == 8'h53, "R3 enable echo 0x53", r[15:8], 8'h53);

    // sweep every page and word with four load orderings
    for (int p = 0; p < PAGES; p++) begin
      for (int w = 0; w < WORDS; w++) begin
        d = pat(p, w);
        case (w % 4)
          0: begin
            instr(C_LLO, 8'h00, 8'(w), d[7:0], r);
            chk(r[23:16] == C_LLO && r[7:0] == 8'(w), "R3 load echo", r, {8'h00, C_LLO, 8'h00, 8'(w)});
            instr(C_LHI, 8'h00, 8'(w), d[15:8], r);
            expm[p][w] = d;
          end
          1: instr(C_LHI, 8'h00, 8'(w), d[15:8], r);
          2: instr(C_LLO, 8'h00, 8'(w), d[7:0], r);
          default: begin
            instr(C_LHI, 8'h00, 8'(w), ~d[15:8], r);
            instr(C_LLO, 8'h00, 8'(w), d[7:0], r);
            instr(C_LHI, 8'h00, 8'(w), d[15:8], r);
            expm[p][w] = d;
          end
        endcase
      end
      c0 = ccount;
      instr(C_WR, 8'(p) | 8'h7C, 8'h00, 8'h00, r);
      repeat (2) @(negedge clk);
      chk(ccount == c0 + 1, "R7 commit pulse", ccount, c0 + 1);
      instr(C_POLL, 8'h00, 8'h00, 8'h00, r);
      chk(r[7:0] == 8'h01, "R9 poll while busy", r[7:0], 8'h01);
      wait_idle();
      chk(busy_len == BUSY, "R8 busy length", busy_len, BUSY);
      instr(C_POLL, 8'h00, 8'h00, 8'h00, r);
      chk(r[7:0] == 8'h00, "R9 poll when idle", r[7:0], 8'h00);
    end

    // R10: instructions during busy are ignored
    instr(C_LLO, 8'h00, 8'h02, 8'h5C, r);
    instr(C_LHI, 8'h00, 8'h02, 8'hE1, r);
    instr(C_WR, 8'h01, 8'h00, 8'h00, r);
    expm[1][2] = 16'hE15C;
    c0 = ccount;
    instr(C_LLO, 8'h00, 8'h03, 8'hAA, r);
    instr(C_LHI, 8'h00, 8'h03, 8'hBB, r);
    instr(C_WR, 8'h02, 8'h00, 8'h00, r);
    chk(ccount == c0, "R10 write while busy", ccount, c0);
    instr(C_RLO, 8'h01, 8'h02, 8'h00, r);
    chk(r[7:0] == 8'h02, "R10 read while busy echoes", r[7:0], 8'h02);
    wait_idle();
    instr(C_WR, 8'h01, 8'h00, 8'h00, r);
    repeat (2) @(negedge clk);
    chk(ccount == c0 + 1, "R7 commit after busy", ccount, c0 + 1);
    wait_idle();

    // R11: hold release mid-frame clears framing and enable
    begin
      logic [7:0] junk;
      xbyte(8'hAC, junk);
      for (int i = 0; i < 5; i++) begin
        mosi = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
    hold = 1'b0;
    repeat (10) @(negedge clk);
    chk(miso == 1'b0, "R11 miso low on release", miso, 0);
    hold = 1'b1;
    repeat (10) @(negedge clk);
    c0 = ccount;
    instr(C_WR, 8'h00, 8'h00, 8'h00, r);
    repeat (4) @(negedge clk);
    chk(ccount == c0, "R11 enable cleared", ccount, c0);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk(r[15:8] == 8'h53, "R11 resync echo", r[15:8], 8'h53);

    // read back whole array
    for (int p = 0; p < PAGES; p++) begin
      for (int w = 0; w < WORDS; w++) begin
        instr(C_RLO, 8'(p), 8'(w), 8'h00, r);
        chk(r[7:0] == expm[p][w][7:0],
            (w % 4 == 1) ? "R6 read low" : (w % 4 == 2) ? "R7 read low" : "R12 R5 read low",
            r[7:0], expm[p][w][7:0]);
        instr(C_RHI, 8'(p), 8'(w), 8'h00, r);
        chk(r[7:0] == expm[p][w][15:8],
            (w % 4 == 1) ? "R6 read high" : (w % 4 == 2) ? "R7 read high" : "R12 read high",
            r[7:0], expm[p][w][15:8]);
      end
    end

    chk(edge_err == 0, "R1 miso stable while sck high", edge_err, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule